// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This block sequences the four switches of a full bridge so that the winding current stays near a limit set by an external comparator. While enabled, it closes the diagonal pair chosen by the direction input. When the current-trip input asserts after the blanking window, it opens that pair and runs an off-time of fixed length. The off-time starts with a fast-decay half that drives the opposite diagonal. All switches then open for a short crossover gap. The off-time ends with slow decay, in which both low sides are on. When the off-time ends, drive resumes and a new blanking window starts.

During decay the switches that conduct the recirculating current act as synchronous rectifiers. Once the zero-current input reports that the current has reached zero, the block opens every switch for the rest of that off-time, so the current cannot build up in reverse. A change of direction or a drop of enable abandons the current cycle at once. In both cases every switch opens for a crossover gap before any new drive. The blank time, the off-time and the crossover gap are counts of clock cycles, set by parameters.

Top module: `mixed_decay_chopper`

## Requirements
- R1: In reset, and from the first clock after `enable` is sampled low in any phase, all four switch outputs and `chopping` are low. They stay low while `enable` stays low.
- R2: When `enable` is sampled high while the block is idle, all switches stay off for XOVER_CYC cycles. Drive then begins. Forward (`dir_fwd`=1) closes `a_hi` and `b_lo`, which is pattern {a_hi,a_lo,b_hi,b_lo}=1001. Reverse closes `b_hi` and `a_lo`, which is pattern 0110.
- R3: During the first BLANK_CYC cycles of every on-period, `trip` has no effect and drive continues.
- R4: A `trip` sampled high after the blanking window ends the on-period on the next cycle. `chopping` then stays high for exactly OFF_CYC cycles.
- R5: During the first OFF_CYC/2 cycles of the off-time, the bridge drives the diagonal opposite to the commanded one (fast decay).
- R6: After the fast half, all switches are off for XOVER_CYC cycles. Both low sides (pattern 0101) are then on for the remaining OFF_CYC - OFF_CYC/2 - XOVER_CYC cycles.
- R7: When `zero_i` is sampled high during the off-time, all switches are off from the next cycle until the off-time ends.
- R8: When the off-time expires, drive of the commanded diagonal resumes with `chopping` low, and a fresh blanking window starts.
- R9: A change of `dir_fwd` sampled while enabled aborts any phase. From the next cycle all switches are off and `chopping` is low for XOVER_CYC cycles. The new diagonal is then driven.
- R10: No leg ever has its high and low switches on together.
- R11: `trip` during the off-time or while disabled has no effect. `zero_i` during an on-period has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Bridge enable |
| dir_fwd | input | 1 | Direction command: 1 forward, 0 reverse |
| trip | input | 1 | Current-trip comparator flag |
| zero_i | input | 1 | Zero-current flag |
| a_hi | output | 1 | Leg A high-side switch on |
| a_lo | output | 1 | Leg A low-side switch on |
| b_hi | output | 1 | Leg B high-side switch on |
| b_lo | output | 1 | Leg B low-side switch on |
| chopping | output | 1 | High throughout the fixed off-time |

## Verification
The bench builds the block with BLANK_CYC=4, OFF_CYC=12 and XOVER_CYC=2. This gives a six-cycle fast half, a two-cycle gap and a four-cycle slow half. Because the timings are so short, a few hundred cycles cover several complete chop periods in both directions. They also cover an abort during fast decay, a disable during the off-time, and zero-current cutoffs that land in different phases. Every phase boundary in these runs is checked cycle by cycle against a count derived from the three parameters.

// File: rtl/chop_pkg.sv
// Shared types for the mixed-decay chopper.
// Assumes: all blocks of the chopper import this package.
package chop_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,   // disabled, all switches open
        PH_GAP,    // crossover gap before new drive
        PH_DRIVE,  // on-period, commanded diagonal closed
        PH_FAST,   // fast-decay half of the off-time
        PH_SPLIT,  // forced all-off gap between decay halves
        PH_SLOW    // slow-decay remainder of the off-time
    } phase_t;
endpackage

// File: rtl/chop_timer.sv
// Phase down-counter: it loads a duration when a phase is entered and then
// counts down to zero and holds there.
// Assumes: the sequencer decides when to load and what each count means.
module chop_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    // Load a new duration, or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/chop_seq.sv
// Phase sequencer: it steps the bridge through gap, drive, fast decay,
// split gap and slow decay. It holds the latched direction and the
// zero-current cutoff flag.
// Assumes: XOVER_CYC >= 1, and OFF_CYC/2 >= 1, and
// OFF_CYC - OFF_CYC/2 - XOVER_CYC >= 1.
module chop_seq
    import chop_pkg::*;
#(
    parameter int BLANK_CYC = 375,
    parameter int OFF_CYC   = 3125,
    parameter int XOVER_CYC = 50,
    parameter int CW        = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          dir_fwd,
    input  logic          trip,
    input  logic          zero_i,
    input  logic [CW-1:0] count,
    output logic          load,
    output logic [CW-1:0] load_val,
    output phase_t        phase,
    output logic          dir_q,
    output logic          zero_q
);
    localparam int FAST_CYC = OFF_CYC / 2;
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC - XOVER_CYC;
    localparam logic [CW-1:0] LV_BLANK = CW'(BLANK_CYC);
    localparam logic [CW-1:0] LV_FAST  = CW'(FAST_CYC);
    localparam logic [CW-1:0] LV_XOVER = CW'(XOVER_CYC);
    localparam logic [CW-1:0] LV_SLOW  = CW'(SLOW_CYC);
    localparam logic [CW-1:0] ONE      = CW'(1);

    phase_t nxt;
    logic   set_dir;
    logic   decaying;
    logic   clr_zero;

    assign decaying = (phase == PH_FAST) || (phase == PH_SPLIT) || (phase == PH_SLOW);
    assign clr_zero = load && ((nxt == PH_DRIVE) || (nxt == PH_FAST));

    // Choose the next phase and the duration to load on entering it.
    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        set_dir  = 1'b0;
        if (!enable) begin
            nxt = PH_IDLE;
        end else if ((phase == PH_IDLE) || (dir_fwd != dir_q)) begin
            nxt      = PH_GAP;
            load     = 1'b1;
            load_val = LV_XOVER;
            set_dir  = 1'b1;
        end else begin
            unique case (phase)
                PH_GAP: if (count == ONE) begin
                    nxt = PH_DRIVE; load = 1'b1; load_val = LV_BLANK;
                end
                PH_DRIVE: if (trip && (count == '0)) begin
                    nxt = PH_FAST; load = 1'b1; load_val = LV_FAST;
                end
                PH_FAST: if (count == ONE) begin
                    nxt = PH_SPLIT; load = 1'b1; load_val = LV_XOVER;
                end
                PH_SPLIT: if (count == ONE) begin
                    nxt = PH_SLOW; load = 1'b1; load_val = LV_SLOW;
                end
                PH_SLOW: if (count == ONE) begin
                    nxt = PH_DRIVE; load = 1'b1; load_val = LV_BLANK;
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    // Register the phase, the direction in use and the rectifier cutoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            dir_q  <= 1'b1;
            zero_q <= 1'b0;
        end else begin
            phase <= nxt;
            if (set_dir)
                dir_q <= dir_fwd;
            if (clr_zero)
                zero_q <= 1'b0;
            else if (zero_i && decaying)
                zero_q <= 1'b1;
        end
    end
endmodule

// File: rtl/chop_gates.sv
// Switch decode: it maps the phase, the direction in use and the zero-current
// cutoff onto the high and low switch of each leg (index 0 is leg A).
// Assumes: inputs come straight from registers, so the outputs are free of
// glitches caused by the block's own inputs.
module chop_gates
    import chop_pkg::*;
(
    input  phase_t     phase,
    input  logic       dir_q,
    input  logic       zero_q,
    output logic [1:0] hi,
    output logic [1:0] lo,
    output logic       chopping
);
    logic drive_on;
    logic fast_on;
    logic slow_on;

    assign drive_on = (phase == PH_DRIVE);
    assign fast_on  = (phase == PH_FAST) && !zero_q;
    assign slow_on  = (phase == PH_SLOW) && !zero_q;
    assign chopping = (phase == PH_FAST) || (phase == PH_SPLIT) || (phase == PH_SLOW);

    for (genvar g = 0; g < 2; g++) begin : g_leg
        logic is_src;
        // A leg sources current when its side matches the direction in use.
        assign is_src = (g == 0) ? dir_q : !dir_q;
        // The source leg's high side drives; in fast decay the other leg's high side rectifies.
        assign hi[g] = (drive_on && is_src) || (fast_on && !is_src);
        // The sink leg's low side drives; slow decay closes both low sides.
        assign lo[g] = (drive_on && !is_src) || (fast_on && is_src) || slow_on;
    end
endmodule

// File: rtl/mixed_decay_chopper.sv
// Top of the fixed off-time mixed-decay chopper: it joins the phase timer,
// the sequencer and the switch decode.
// Assumes: trip and zero_i are already synchronous to clk.
module mixed_decay_chopper #(
    parameter int BLANK_CYC = 375,
    parameter int OFF_CYC   = 3125,
    parameter int XOVER_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dir_fwd,
    input  logic trip,
    input  logic zero_i,
    output logic a_hi,
    output logic a_lo,
    output logic b_hi,
    output logic b_lo,
    output logic chopping
);
    import chop_pkg::*;

    localparam int MAXC = (BLANK_CYC > OFF_CYC) ? BLANK_CYC : OFF_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic          load;
    logic [CW-1:0] load_val;
    logic [CW-1:0] count;
    phase_t        phase;
    logic          dir_q;
    logic          zero_q;
    logic [1:0]    hi;
    logic [1:0]    lo;

    chop_timer #(.W(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .count(count)
    );

    chop_seq #(
        .BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC), .XOVER_CYC(XOVER_CYC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dir_fwd(dir_fwd),
        .trip(trip), .zero_i(zero_i), .count(count), .load(load),
        .load_val(load_val), .phase(phase), .dir_q(dir_q), .zero_q(zero_q)
    );

    chop_gates u_gates (
        .phase(phase), .dir_q(dir_q), .zero_q(zero_q),
        .hi(hi), .lo(lo), .chopping(chopping)
    );

    assign a_hi = hi[0];
    assign a_lo = lo[0];
    assign b_hi = hi[1];
    assign b_lo = lo[1];
endmodule

// File: rtl/chop_props.sv
// Port-level properties of the mixed-decay chopper, bound to its top.
// Assumes: only the top module's ports are observed.
module chop_props (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic dir_fwd,
    input logic trip,
    input logic zero_i,
    input logic a_hi,
    input logic a_lo,
    input logic b_hi,
    input logic b_lo,
    input logic chopping
);
    logic all_off;
    logic both_lo;
    assign all_off = !(a_hi || a_lo || b_hi || b_lo);
    assign both_lo = a_lo && b_lo;

    // R10
    leg_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && a_lo) && !(b_hi && b_lo));

    // R1
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (all_off && !chopping));

    // R9
    dir_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (dir_fwd != $past(dir_fwd))) |=> (all_off && !chopping));

    // R4
    chop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chopping) |-> $past(trip));

    // R6
    slow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_lo && !$past(both_lo)) |-> $past(all_off));

    // R7
    zero_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chopping) && $past(zero_i) && chopping) |-> all_off);
endmodule

bind mixed_decay_chopper chop_props u_props (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir_fwd(dir_fwd),
    .trip(trip), .zero_i(zero_i), .a_hi(a_hi), .a_lo(a_lo),
    .b_hi(b_hi), .b_lo(b_lo), .chopping(chopping)
);

// File: tb/mixed_decay_chopper_test.sv
// Scoreboard bench: driver tasks apply one cycle of stimulus and queue the
// expected outputs for the following cycle. A monitor pops and compares them.
module mixed_decay_chopper_test;
    localparam int BLK  = 4;
    localparam int OFF  = 12;
    localparam int XOV  = 2;
    localparam int FST  = OFF / 2;
    localparam int SLW  = OFF - FST - XOV;

    typedef struct {
        int         due;
        logic [3:0] pat;
        logic       chop;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic dir_fwd = 1'b1;
    logic trip = 1'b0;
    logic zero_i = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo, chopping;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    mixed_decay_chopper #(.BLANK_CYC(BLK), .OFF_CYC(OFF), .XOVER_CYC(XOV)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dir_fwd(dir_fwd),
        .trip(trip), .zero_i(zero_i), .a_hi(a_hi), .a_lo(a_lo),
        .b_hi(b_hi), .b_lo(b_lo), .chopping(chopping)
    );

    // Count rising edges so queued items know when they fall due.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that falls due on this falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            n_run++;
            if ({a_hi, a_lo, b_hi, b_lo} !== it.pat || chopping !== it.chop) begin
                n_fail++;
                $display("FAIL %s cycle %0d: got sw=%b chop=%b expected sw=%b chop=%b",
                         it.req, cyc, {a_hi, a_lo, b_hi, b_lo}, chopping, it.pat, it.chop);
            end
        end
    end

    function automatic logic [3:0] drv(input logic d);
        return d ? 4'b1001 : 4'b0110;
    endfunction

    // One cycle of stimulus, with the outputs expected one cycle later.
    task automatic step(input logic en, input logic d, input logic tr, input logic z,
                        input logic [3:0] pat, input logic ch, input string req);
        exp_t e;
        @(negedge clk);
        enable  = en;
        dir_fwd = d;
        trip    = tr;
        zero_i  = z;
        e.due  = cyc + 1;
        e.pat  = pat;
        e.chop = ch;
        e.req  = req;
        q.push_back(e);
    endtask

    // Enable or change direction: crossover gap, then the first drive cycle.
    task automatic start(input logic d, input string req);
        for (int i = 0; i < XOV; i++) step(1'b1, d, 1'b0, 1'b0, 4'b0000, 1'b0, req);
        step(1'b1, d, 1'b0, 1'b0, drv(d), 1'b0, req);
    endtask

    // On-period: trips inside the blanking window are ignored (R3), and so is
    // a zero flag while driving (R11).
    task automatic run_on(input logic d, input int extra);
        for (int i = 0; i < BLK; i++) step(1'b1, d, 1'b1, 1'b0, drv(d), 1'b0, "R3");
        for (int i = 0; i < extra; i++) step(1'b1, d, 1'b0, 1'b1, drv(d), 1'b0, "R11");
    endtask

    // Trip plus a whole off-time: R4 to R7, then the return to drive (R8).
    task automatic run_off(input logic d, input int zk, input logic trip_in_off);
        bit cut = 1'b0;
        for (int k = 0; k < OFF; k++) begin
            logic [3:0] p;
            string      r;
            if (zk >= 1 && k == zk) cut = 1'b1;
            if (k < FST) begin
                p = drv(!d); r = (k == 0) ? "R4" : "R5";
            end else if (k < FST + XOV) begin
                p = 4'b0000; r = "R6";
            end else begin
                p = 4'b0101; r = "R6";
            end
            if (cut) begin
                p = 4'b0000; r = "R7";
            end
            if (trip_in_off && k > 0 && !cut) r = "R11";
            step(1'b1, d, (k == 0) || trip_in_off, (k == zk), p, 1'b1, r);
        end
        step(1'b1, d, 1'b0, 1'b0, drv(d), 1'b0, "R8");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no end, expected end of sequence");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, trip while disabled has no effect (R11)
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, "R11");
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, "R1");
        // Forward: plain cycle, then zero cut mid fast half with trips in off-time
        start(1'b1, "R2");
        run_on(1'b1, 2);
        run_off(1'b1, -1, 1'b0);
        run_on(1'b1, 0);
        run_off(1'b1, 3, 1'b1);
        run_on(1'b1, 1);
        run_off(1'b1, FST + XOV + 1, 1'b0);   // zero during slow half, R7
        // Direction change during drive, R9
        start(1'b0, "R9");
        run_on(1'b0, 1);
        run_off(1'b0, -1, 1'b0);
        run_on(1'b0, 0);
        run_off(1'b0, FST, 1'b0);             // zero in split gap, R7
        // Abort during fast decay by a direction change, R9
        run_on(1'b0, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0, drv(1'b1), 1'b1, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, drv(1'b1), 1'b1, "R5");
        start(1'b1, "R9");
        // Disable during the on-period, R1
        run_on(1'b1, 0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R1");
        // Re-enable; zero flag in the trip cycle is ignored (R11)
        start(1'b1, "R2");
        run_on(1'b1, 0);
        run_off(1'b1, 0, 1'b0);
        // Disable during the off-time, R1
        run_on(1'b1, 0);
        step(1'b1, 1'b1, 1'b1, 1'b0, drv(1'b0), 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R1");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: got %0d pending, expected 0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule